// File: doc/BRIEF.md
# Back-Porch Clamp Window Generator

This block produces one clamp-enable pulse per horizontal video line, placed in the back porch. It runs on the pixel clock. It watches a horizontal sync input whose active level is programmable. It counts a programmed number of pixel periods from the end of sync, and then holds a clamp strobe high for a programmed number of pixel periods. Because the window is counted from the end of sync and not from its start, the clamp never lands on the sync tip.

For each of three video channels, the block also presents the black code that downstream offset correction should aim for. Each channel uses ground (0x00) for RGB-style channels or midscale (0x80) for colour-difference channels, chosen per channel. A small register port holds the placement, the duration, the polarity and the channel selects. All of these can be read back. A new placement, duration or select setting applies only from the next end of sync, so a window already running is never changed.

Top module: `clamp_timing_gen`

## Requirements
- R1: The window is counted from clock edge E0, the first rising clock edge at which hsyncIn is sampled at its inactive level after an edge that sampled it active; the start of sync does not start a window.
- R2: With placement P (address 0, 8 bits), clampActive is first high in the cycle after edge E0+1+P, so P=0 raises it right after edge E0+1.
- R3: With duration D (address 1, 8 bits), clampActive stays high for exactly D consecutive cycles.
- R4: A duration of 0 produces no clamp pulse for that line, and it cancels any window still running.
- R5: Control bit 0 (address 2) sets the sync polarity: 0 means hsyncIn is active high, 1 means active low. The polarity is applied before edge detection.
- R6: A new end of sync while the placement count or the clamp window is still running restarts the sequence from the new edge.
- R7: Writes to placement, duration or channel selects take effect at the next end of sync (edge E0+1); a window in progress keeps its old values.
- R8: Control bits 4, 5 and 6 select the clamp target of channels 0, 1 and 2. A bit value of 0 gives black code 0x00 and a value of 1 gives 0x80. blackCodes[c] takes the new value after edge E0+1.
- R9: After reset, placement reads 0x08, duration 0x14 and control 0x00; clampActive is low and all black codes are 0x00.
- R10: A write at a clock edge is visible on regRdData right after that edge. Control bits 1 to 3 and 7 read as 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncIn | input | 1 | Horizontal sync, polarity set by control bit 0 |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write address (0 placement, 1 duration, 2 control) |
| regWrData | input | 8 | Write data |
| regRdAddr | input | 2 | Read address |
| regRdData | output | 8 | Read data for regRdAddr |
| clampActive | output | 1 | Clamp-enable window |
| blackCodes | output | 3x8 | Target black code per channel, channel 0 in the low byte |

## Verification
The input register and the end-of-sync detector add two edges: the window begins after edge E0+1+P and lasts D cycles. The black codes move after edge E0+1, and read data follows a write with no added edge. The bench drives inputs one time unit after a rising edge. A behavioural model takes the same samples at each rising edge and keeps the expected window as edge numbers. Outputs are compared on every falling edge, so each check lands in the cycle in which its result is due. Placement, duration, polarity, restart and mid-window writes are each covered by their own stretch of stimulus.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NUM_CH  = 3;
  localparam int SEL_LSB = 4;
  localparam int POL_BIT = 0;

  localparam logic [ADDR_W-1:0] ADDR_PLACE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUR   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;

  localparam logic [DATA_W-1:0] RESET_PLACE = 8'h08;
  localparam logic [DATA_W-1:0] RESET_DUR   = 8'h14;

  typedef struct packed {
    logic capture;
    logic loadPlace;
    logic loadDur;
    logic countDown;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CLAMP} clampState_t;
endpackage

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NCH = NUM_CH,
  parameter int SELB = SEL_LSB
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hsyncIn,
  input  logic                    regWrEn,
  input  logic [AW-1:0]           regWrAddr,
  input  logic [DW-1:0]           regWrData,
  input  logic [AW-1:0]           regRdAddr,
  input  ctlStrobe_t              strobe,
  output logic [DW-1:0]           regRdData,
  output logic                    trailPulse,
  output logic                    placeIsZero,
  output logic                    durIsZero,
  output logic                    cntZero,
  output logic [NCH-1:0][DW-1:0]  blackCodes
);
  localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] GND_CODE = '0;

  logic [DW-1:0]  placeShadow, durShadow, activeDur, cnt;
  logic           polShadow;
  logic [NCH-1:0] selShadow, selActive;
  logic           syncNowQ, syncPrevQ;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      placeShadow <= RESET_PLACE;
      durShadow   <= RESET_DUR;
      polShadow   <= 1'b0;
      selShadow   <= '0;
    end else if (regWrEn) begin
      case (regWrAddr)
        ADDR_PLACE: placeShadow <= regWrData;
        ADDR_DUR:   durShadow   <= regWrData;
        ADDR_CTRL: begin
          polShadow <= regWrData[POL_BIT];
          selShadow <= regWrData[SELB +: NCH];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      ADDR_PLACE: regRdData = placeShadow;
      ADDR_DUR:   regRdData = durShadow;
      ADDR_CTRL: begin
        regRdData[POL_BIT]        = polShadow;
        regRdData[SELB +: NCH]    = selShadow;
      end
      default: regRdData = '0;
    endcase
  end

  // polarity-normalised sync sampling and trailing-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncNowQ  <= 1'b0;
      syncPrevQ <= 1'b0;
    end else begin
      syncNowQ  <= hsyncIn ^ polShadow;
      syncPrevQ <= syncNowQ;
    end
  end
  assign trailPulse = syncPrevQ & ~syncNowQ;

  // settings latched per line, and the shared down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDur <= RESET_DUR;
      selActive <= '0;
      cnt       <= '0;
    end else begin
      if (strobe.capture) begin
        activeDur <= durShadow;
        selActive <= selShadow;
      end
      if (strobe.loadPlace)
        cnt <= placeShadow - DW'(1);
      else if (strobe.loadDur)
        cnt <= (strobe.capture ? durShadow : activeDur) - DW'(1);
      else if (strobe.countDown)
        cnt <= cnt - DW'(1);
    end
  end

  assign placeIsZero = (placeShadow == '0);
  assign durIsZero   = (durShadow == '0);
  assign cntZero     = (cnt == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_code
    assign blackCodes[ch] = selActive[ch] ? MID_CODE : GND_CODE;
  end
endmodule

// File: rtl/clamp_control.sv
module clamp_control
  import clamp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trailPulse,
  input  logic       placeIsZero,
  input  logic       durIsZero,
  input  logic       cntZero,
  output ctlStrobe_t strobe,
  output logic       clampActive
);
  clampState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (trailPulse) begin
      strobe.capture = 1'b1;
      if (durIsZero) begin
        stateNext = ST_IDLE;
      end else if (placeIsZero) begin
        strobe.loadDur = 1'b1;
        stateNext      = ST_CLAMP;
      end else begin
        strobe.loadPlace = 1'b1;
        stateNext        = ST_WAIT;
      end
    end else begin
      case (state)
        ST_WAIT: begin
          if (cntZero) begin
            strobe.loadDur = 1'b1;
            stateNext      = ST_CLAMP;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        ST_CLAMP: begin
          if (cntZero) stateNext = ST_IDLE;
          else         strobe.countDown = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign clampActive = (state == ST_CLAMP);
endmodule

// File: rtl/clamp_timing_gen.sv
module clamp_timing_gen
  import clamp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hsyncIn,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regWrAddr,
  input  logic [DATA_W-1:0]             regWrData,
  input  logic [ADDR_W-1:0]             regRdAddr,
  output logic [DATA_W-1:0]             regRdData,
  output logic                          clampActive,
  output logic [NUM_CH-1:0][DATA_W-1:0] blackCodes
);
  ctlStrobe_t strobe;
  logic trailPulse, placeIsZero, durIsZero, cntZero;

  clamp_datapath u_dp (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .strobe(strobe), .regRdData(regRdData),
    .trailPulse(trailPulse), .placeIsZero(placeIsZero),
    .durIsZero(durIsZero), .cntZero(cntZero), .blackCodes(blackCodes)
  );

  clamp_control u_ctl (
    .clk(clk), .rstN(rstN), .trailPulse(trailPulse),
    .placeIsZero(placeIsZero), .durIsZero(durIsZero), .cntZero(cntZero),
    .strobe(strobe), .clampActive(clampActive)
  );
endmodule

// File: rtl/clamp_timing_checker.sv
module clamp_timing_checker
  import clamp_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          trailPulse,
  input logic                          placeIsZero,
  input logic                          durIsZero,
  input logic                          clampActive,
  input logic [NUM_CH-1:0][DATA_W-1:0] blackCodes
);
  // R1: an end-of-sync detection is a single-cycle event
  p_trail_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    trailPulse |=> !trailPulse);

  // R2: zero placement starts the clamp on the next cycle
  p_place_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trailPulse && placeIsZero && !durIsZero) |=> clampActive);

  // R4: zero duration gives no clamp
  p_zero_dur_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trailPulse && durIsZero) |=> !clampActive);

  // R6: a fresh edge with nonzero placement drops a running window
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trailPulse && !placeIsZero) |=> !clampActive);

  // R8: black codes only move right after an end of sync
  p_codes_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !trailPulse |=> $stable(blackCodes));
endmodule

bind clamp_timing_gen clamp_timing_checker u_chk (
  .clk(clk), .rstN(rstN), .trailPulse(trailPulse),
  .placeIsZero(placeIsZero), .durIsZero(durIsZero),
  .clampActive(clampActive), .blackCodes(blackCodes)
);

// File: tb/clamp_timing_gen_tb.sv
module clamp_timing_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic [1:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic clampActive;
  logic [2:0][7:0] blackCodes;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit benchPol = 0;

  // reference model state
  int  edgeNo = 0;
  int  winStart = 0, winEnd = 0;
  bit  pendTrail = 0, prevNorm = 0;
  logic [7:0] mPlace = 8'h08, mDur = 8'h14, mCtrl = 8'h00;
  logic [2:0] mSel = 3'b000;

  clamp_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .clampActive(clampActive), .blackCodes(blackCodes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model: advance on each rising edge from the inputs held stable there
  always @(posedge clk) begin
    if (!rstN) begin
      edgeNo = 0; winStart = 0; winEnd = 0; pendTrail = 0; prevNorm = 0;
      mPlace = 8'h08; mDur = 8'h14; mCtrl = 8'h00; mSel = 3'b000;
    end else begin
      bit norm;
      edgeNo++;
      if (pendTrail) begin
        winStart = edgeNo + int'(mPlace);
        winEnd   = winStart + int'(mDur);
        mSel     = mCtrl[6:4];
      end
      norm      = hsyncIn ^ mCtrl[0];
      pendTrail = prevNorm && !norm;
      prevNorm  = norm;
      if (regWrEn) begin
        case (regWrAddr)
          2'd0: mPlace = regWrData;
          2'd1: mDur   = regWrData;
          2'd2: mCtrl  = regWrData & 8'h71;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at edge %0d: actual 0x%0h expected 0x%0h", tag, edgeNo, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expClamp;
      logic [7:0] expRd;
      expClamp = (edgeNo >= winStart) && (edgeNo < winEnd);
      check(clampActive == expClamp, "R1 R2 R3 R4 R5 R6 R7 clamp window",
            int'(clampActive), int'(expClamp));
      for (int c = 0; c < 3; c++)
        check(blackCodes[c] == (mSel[c] ? 8'h80 : 8'h00), "R8 black code",
              int'(blackCodes[c]), mSel[c] ? 'h80 : 0);
      case (regRdAddr)
        2'd0: expRd = mPlace;
        2'd1: expRd = mDur;
        2'd2: expRd = mCtrl;
        default: expRd = 8'h00;
      endcase
      check(regRdData == expRd, "R10 readback", int'(regRdData), int'(expRd));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regRdAddr = a;
    if (a == 2'd2) benchPol = d[0];
  endtask

  task automatic line(input int syncLen, input int gapLen);
    hsyncIn = ~benchPol;
    for (int i = 0; i < syncLen; i++) begin
      regRdAddr = 2'(i);
      step();
    end
    hsyncIn = benchPol;
    for (int i = 0; i < gapLen; i++) begin
      regRdAddr = 2'(i);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    #1 rstN = 1'b1;
    step();
    // R9: reset contents
    regRdAddr = 2'd0; #1;
    check(regRdData == 8'h08, "R9 reset placement", int'(regRdData), 'h08);
    regRdAddr = 2'd1; #1;
    check(regRdData == 8'h14, "R9 reset duration", int'(regRdData), 'h14);
    regRdAddr = 2'd2; #1;
    check(regRdData == 8'h00, "R9 reset control", int'(regRdData), 0);
    check(clampActive == 1'b0 && blackCodes == '0, "R9 reset outputs",
          int'(clampActive), 0);
    step();
    // R1 R2 R3: default window
    line(10, 50); line(10, 50);
    // R2: placement 0
    wr(2'd0, 8'd0); wr(2'd1, 8'd5);
    line(8, 40); line(8, 40);
    // R4: zero duration
    wr(2'd0, 8'd3); wr(2'd1, 8'd0);
    line(8, 30);
    wr(2'd0, 8'd1); wr(2'd1, 8'd1);
    line(4, 20);
    wr(2'd0, 8'd200); wr(2'd1, 8'd3);
    line(4, 230);
    // R5 R8: active-low sync, midscale selects, unused bits ignored
    wr(2'd2, 8'hFF);
    regRdAddr = 2'd2; step();
    line(6, 40); line(6, 40);
    wr(2'd2, 8'h51);
    wr(2'd0, 8'd8); wr(2'd1, 8'd20);
    line(6, 45);
    // R6: edges arriving during placement and during the window
    line(5, 6); line(5, 12); line(5, 14);
    line(5, 60);
    // R7: write while a window is running
    wr(2'd2, 8'h20);
    hsyncIn = ~benchPol; repeat (5) step();
    hsyncIn = benchPol;  repeat (14) step();
    wr(2'd1, 8'd2); wr(2'd0, 8'd0); wr(2'd2, 8'h40);
    repeat (30) step();
    line(5, 30);
    // R3: maximum placement and duration
    wr(2'd0, 8'd255); wr(2'd1, 8'd255);
    line(3, 600);
    // R10: unused address
    regRdAddr = 2'd3; step();
    step();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule